// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns one 32-bit instruction word into the control lines of a single-cycle datapath. It recognises a small instruction set: register add, subtract, AND and OR; a load-immediate; word load and store; an absolute jump; a register jump; and the equal and not-equal branches. From the major opcode it drives source, destination, write-enable, memory and next-PC selects, and it drives a 2-bit ALU class.

A second stage combines that ALU class with the function field to pick a 3-bit ALU operation. The same stage flags a register jump. The whole path is combinational: the outputs follow the instruction word in the same cycle, with no clock and no state. The opcode is bits 31:26 of the word and the function field is bits 5:0.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Opcode 001111 (load-immediate) sets alu_src, reg_wr and load_imm, clears every other control line, and gives alu_op 00 and alu_sel 010.
- R2: Opcode 000000 sets reg_dst and reg_wr, clears the other control lines and gives alu_op 10. Function codes 100000, 100010, 100100 and 100101 give alu_sel 010 (add), 110 (subtract), 000 (AND) and 001 (OR).
- R3: When alu_op is 00, alu_sel is 010 whatever bits 5:0 of the word hold.
- R4: Opcode 000000 with function 001000 raises jump_reg and forces reg_wr low. It keeps reg_dst 1, alu_op 10 and alu_sel 010.
- R5: jump_reg is 0 whenever the opcode is not 000000, even if bits 5:0 equal 001000.
- R6: Opcode 100011 (load word) sets alu_src, mem_rd, mem_to_reg and reg_wr, with alu_op 00.
- R7: Opcode 101011 (store word) sets alu_src and mem_wr only, with alu_op 00.
- R8: Opcode 000100 sets branch_eq and opcode 000101 sets branch_ne. Both give alu_op 01 and alu_sel 110, with no register or memory write.
- R9: Opcode 000010 sets jump only, with alu_op 00.
- R10: Any other opcode drives all ten control lines, alu_op and jump_reg to 0, and alu_sel to 010.
- R11: Opcode 000000 with a function code outside the five listed gives alu_sel 010, with reg_dst and reg_wr set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| alu_src | output | 1 | ALU second operand from the extended immediate |
| reg_dst | output | 1 | Destination register from bits 15:11 |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| mem_to_reg | output | 1 | Write-back from memory |
| branch_eq | output | 1 | Branch when equal |
| branch_ne | output | 1 | Branch when not equal |
| jump | output | 1 | Absolute jump |
| load_imm | output | 1 | Write-back of the immediate |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 by function |
| alu_sel | output | 3 | ALU operation code |
| jump_reg | output | 1 | Register jump |

## Verification
Every supported opcode is applied with realistic register fields, so each control line is shown to belong to the right instruction only. The four arithmetic and logic function codes separate the second-stage encodings from one another. Immediate-class words are given low bits that look like subtract, OR or register-jump function codes, which shows that the function field is masked outside the register class. An unknown opcode, an unknown function code and the all-zero word cover the fallback values.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int OPC_LSB = INSTR_W - OPC_W;

    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [FN_W-1:0]  fn_t;

    localparam opc_t OPC_REG  = 6'b000000;
    localparam opc_t OPC_JMP  = 6'b000010;
    localparam opc_t OPC_BEQ  = 6'b000100;
    localparam opc_t OPC_BNE  = 6'b000101;
    localparam opc_t OPC_LDI  = 6'b001111;
    localparam opc_t OPC_LDW  = 6'b100011;
    localparam opc_t OPC_STW  = 6'b101011;

    localparam fn_t FN_ADD = 6'b100000;
    localparam fn_t FN_SUB = 6'b100010;
    localparam fn_t FN_AND = 6'b100100;
    localparam fn_t FN_OR  = 6'b100101;
    localparam fn_t FN_JR  = 6'b001000;

    typedef enum logic [1:0] {
        CLS_ADD = 2'b00,
        CLS_SUB = 2'b01,
        CLS_FN  = 2'b10,
        CLS_RSV = 2'b11
    } alu_cls_e;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110
    } alu_sel_e;

    typedef struct packed {
        logic     alu_src;
        logic     reg_dst;
        logic     reg_wr;
        logic     mem_rd;
        logic     mem_wr;
        logic     mem_to_reg;
        logic     branch_eq;
        logic     branch_ne;
        logic     jump;
        logic     load_imm;
        alu_cls_e cls;
    } ctrl_t;

    localparam ctrl_t CTRL_NONE = '{default: '0, cls: CLS_ADD};

    function automatic opc_t get_opc(input logic [INSTR_W-1:0] w);
        return w[INSTR_W-1:OPC_LSB];
    endfunction

    function automatic fn_t get_fn(input logic [INSTR_W-1:0] w);
        return w[FN_W-1:0];
    endfunction
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  opc_t  opc,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = CTRL_NONE;
        unique case (opc)
            OPC_REG: begin
                ctrl.reg_dst = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.cls     = CLS_FN;
            end
            OPC_LDI: begin
                ctrl.alu_src  = 1'b1;
                ctrl.reg_wr   = 1'b1;
                ctrl.load_imm = 1'b1;
            end
            OPC_LDW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_rd     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_STW: begin
                ctrl.alu_src = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch_eq = 1'b1;
                ctrl.cls       = CLS_SUB;
            end
            OPC_BNE: begin
                ctrl.branch_ne = 1'b1;
                ctrl.cls       = CLS_SUB;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            default: ctrl = CTRL_NONE;
        endcase
    end

    always_comb begin
        // R6
        ldw_path_chk: assert (!ctrl.mem_rd || (ctrl.mem_to_reg && ctrl.reg_wr && ctrl.alu_src))
            else $error("load path incomplete");
    end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  alu_cls_e cls,
    input  fn_t      fn,
    output alu_sel_e sel,
    output logic     jr
);
    always_comb begin
        sel = OP_ADD;
        unique case (cls)
            CLS_ADD: sel = OP_ADD;
            CLS_SUB: sel = OP_SUB;
            CLS_FN: begin
                unique case (fn)
                    FN_SUB:  sel = OP_SUB;
                    FN_AND:  sel = OP_AND;
                    FN_OR:   sel = OP_OR;
                    default: sel = OP_ADD;
                endcase
            end
            default: sel = OP_ADD;
        endcase
    end

    assign jr = (cls == CLS_FN) && (fn == FN_JR);

    always_comb begin
        // R3
        cls_add_chk: assert (cls != CLS_ADD || sel == OP_ADD)
            else $error("add class gave other operation");
    end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
    import ctl_pkg::*;
(
    input  logic [31:0] instr,
    output logic        alu_src,
    output logic        reg_dst,
    output logic        reg_wr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        mem_to_reg,
    output logic        branch_eq,
    output logic        branch_ne,
    output logic        jump,
    output logic        load_imm,
    output logic [1:0]  alu_op,
    output logic [2:0]  alu_sel,
    output logic        jump_reg
);
    ctrl_t    ctrl;
    alu_sel_e sel;
    logic     jr;

    ctl_main_dec u_main (
        .opc  (get_opc(instr)),
        .ctrl (ctrl)
    );

    ctl_alu_dec u_alu (
        .cls (ctrl.cls),
        .fn  (get_fn(instr)),
        .sel (sel),
        .jr  (jr)
    );

    assign alu_src    = ctrl.alu_src;
    assign reg_dst    = ctrl.reg_dst;
    assign reg_wr     = ctrl.reg_wr & ~jr;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign mem_to_reg = ctrl.mem_to_reg;
    assign branch_eq  = ctrl.branch_eq;
    assign branch_ne  = ctrl.branch_ne;
    assign jump       = ctrl.jump;
    assign load_imm   = ctrl.load_imm;
    assign alu_op     = ctrl.cls;
    assign alu_sel    = sel;
    assign jump_reg   = jr;

    always_comb begin
        // R1
        ldi_ctrl_chk: assert (!load_imm || (alu_src && reg_wr && !mem_rd && !mem_wr && !jump && alu_sel == 3'b010))
            else $error("load-immediate controls wrong");
        // R4
        jr_src_chk: assert (!jump_reg || (instr[31:26] == 6'b000000 && instr[5:0] == 6'b001000 && !reg_wr))
            else $error("register jump misdecoded");
        // R8
        branch_sub_chk: assert (!(branch_eq || branch_ne) || alu_sel == 3'b110)
            else $error("branch without subtract");
        // R9
        next_pc_chk: assert ($onehot0({branch_eq, branch_ne, jump, jump_reg}))
            else $error("several next-PC selects");
        // R7
        mem_excl_chk: assert (!(mem_rd && mem_wr))
            else $error("read and write together");
    end
endmodule

// File: tb/sim_instr_ctrl_decoder.sv
module sim_instr_ctrl_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    // vector: instr[47:16], controls[15:6] {src,dst,wr,rd,wrm,m2r,beq,bne,j,li}, alu_op[5:4], alu_sel[3:1], jr[0]
    localparam logic [47:0] VEC [NVEC] = '{
        {32'h3C100008, 10'b1010000001, 2'b00, 3'b010, 1'b0}, // R1 li
        {32'h01095020, 10'b0110000000, 2'b10, 3'b010, 1'b0}, // R2 add
        {32'h01095822, 10'b0110000000, 2'b10, 3'b110, 1'b0}, // R2 sub
        {32'h01096824, 10'b0110000000, 2'b10, 3'b000, 1'b0}, // R2 and
        {32'h01097025, 10'b0110000000, 2'b10, 3'b001, 1'b0}, // R2 or
        {32'h3C100022, 10'b1010000001, 2'b00, 3'b010, 1'b0}, // R3 li, low bits like sub
        {32'h8F880025, 10'b1011010000, 2'b00, 3'b010, 1'b0}, // R3 lw, low bits like or
        {32'h03E00008, 10'b0100000000, 2'b10, 3'b010, 1'b1}, // R4 jr
        {32'h20000008, 10'b0000000000, 2'b00, 3'b010, 1'b0}, // R5 unknown opcode, jr funct
        {32'h8F880008, 10'b1011010000, 2'b00, 3'b010, 1'b0}, // R5 lw, jr funct
        {32'h8F880000, 10'b1011010000, 2'b00, 3'b010, 1'b0}, // R6 lw
        {32'hAF900000, 10'b1000100000, 2'b00, 3'b010, 1'b0}, // R7 sw
        {32'h11090003, 10'b0000001000, 2'b01, 3'b110, 1'b0}, // R8 beq
        {32'h15090003, 10'b0000000100, 2'b01, 3'b110, 1'b0}, // R8 bne
        {32'h08000010, 10'b0000000010, 2'b00, 3'b010, 1'b0}, // R9 j
        {32'hFC000020, 10'b0000000000, 2'b00, 3'b010, 1'b0}, // R10 opcode 111111
        {32'h0109502A, 10'b0110000000, 2'b10, 3'b010, 1'b0}, // R11 unknown funct
        {32'hAF900022, 10'b1000100000, 2'b00, 3'b010, 1'b0}  // R7 sw, low bits like sub
    };
    localparam int TAG [NVEC] = '{1, 2, 2, 2, 2, 3, 3, 4, 5, 5, 6, 7, 8, 8, 9, 10, 11, 7};

    logic clk = 1'b0;
    logic [31:0] instr;
    logic alu_src, reg_dst, reg_wr, mem_rd, mem_wr, mem_to_reg;
    logic branch_eq, branch_ne, jump, load_imm, jump_reg;
    logic [1:0] alu_op;
    logic [2:0] alu_sel;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_ctrl_decoder u0 (
        .instr(instr), .alu_src(alu_src), .reg_dst(reg_dst), .reg_wr(reg_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
        .branch_eq(branch_eq), .branch_ne(branch_ne), .jump(jump),
        .load_imm(load_imm), .alu_op(alu_op), .alu_sel(alu_sel), .jump_reg(jump_reg)
    );

    function automatic logic [15:0] outs();
        return {alu_src, reg_dst, reg_wr, mem_rd, mem_wr, mem_to_reg,
                branch_eq, branch_ne, jump, load_imm, alu_op, alu_sel, jump_reg};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [15:0] exp, input int tag);
        @(negedge clk);
        instr = w;
        @(posedge clk);
        #1;
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL R%0d instr=%h actual=%b expected=%b", tag, w, outs(), exp);
        end
    endtask

    initial begin
        instr = 32'h0;
        // R11 state with an all-zero word (no-op register form)
        apply(32'h00000000, {10'b0110000000, 2'b10, 3'b010, 1'b0}, 11);
        for (int i = 0; i < NVEC; i++) apply(VEC[i][47:16], VEC[i][15:0], TAG[i]);
        // R4 jr with nonzero register fields elsewhere still suppresses write
        apply(32'h0120F808, {10'b0100000000, 2'b10, 3'b010, 1'b1}, 4);
        // R10 another unused opcode 111000 with add funct
        apply(32'hE1095020, {10'b0000000000, 2'b00, 3'b010, 1'b0}, 10);
        // R8 beq with low bits like or stays subtract
        apply(32'h11090025, {10'b0000001000, 2'b01, 3'b110, 1'b0}, 8);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule